// File: doc/BRIEF.md
# Remap Configuration Shadow Monitor

This block guards a bank of pin-remap control registers against silent corruption. It holds its own copy of every register. A copy changes only when a write is accepted, which means a write request made while the configuration lock is clear. Every cycle the block compares its copies with the live register contents. If any bit differs when no write explains it, the block raises a configuration-mismatch reset request. The request is registered and stays up until the system reset returns both the live bank and the copies to zero.

The register file sits outside this block. It applies the same acceptance rule, so an accepted write lands in the live register and in the copy on the same clock edge and never shows as a transient mismatch. A write made while locked is dropped by both sides. For test, an injection port flips chosen bits of one copy, which stands in for an upset on the shadow side. A status output reports which register index tripped the monitor first.

The controller has two states. In `MON_ARMED` the block compares the live bank with its copies. The transition *trip* fires on the first clock edge that sees any mismatch: it moves to `MON_TRIPPED` and captures the lowest mismatching index. `MON_TRIPPED` has no exit except the asynchronous reset, which returns to `MON_ARMED`.

Top module: `cfgmon_top`

## Requirements
- R1: After reset, all copies are zero, `mm_reset_req` is 0 and `mm_first_idx` is 0. While the live bank is also zero, no request is raised.
- R2: A write with `wr_req`=1 and `wr_locked`=0 updates the copy at `wr_addr` to `wr_data` on the same clock edge as the live register. Such writes, including back-to-back writes, never raise a request.
- R3: A write with `wr_locked`=1 leaves every copy unchanged. It raises no request while the live bank also ignores it.
- R4: A change to a live register with no accepted write raises `mm_reset_req` on the second rising edge after the change: the first edge makes the change, the next edge registers the request.
- R5: While `inj_en`=1, the bits of `inj_mask` in the copy at `inj_idx` are inverted on the clock edge. A nonzero mask causes a request one edge later. A zero mask has no effect.
- R6: Once raised, `mm_reset_req` stays 1 until reset, even if the live bank returns to match the copies.
- R7: `mm_first_idx` reads 0 while no request is pending. On the trip it captures the lowest index that mismatched on that edge, and it then holds that value while later mismatches at other indices come and go.
- R8: The asynchronous active-low reset `rst_n` clears a pending request and all copies. After release, monitoring resumes normally.
- R9: A single-bit difference at any bit position, including bit W-1 (bit 15 by default) of register NREG-1 and of register 0, trips the monitor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| live_regs | input | NREG*W | Live register bank, register i at bits [i*W +: W] |
| wr_req | input | 1 | Write request from the register-file port |
| wr_locked | input | 1 | Configuration lock; 1 means the write is dropped |
| wr_addr | input | AW | Register index of the write |
| wr_data | input | W | Write data |
| inj_en | input | 1 | Test hook: flip bits in one copy |
| inj_idx | input | AW | Copy index for the flip |
| inj_mask | input | W | Bits to invert in that copy |
| mm_reset_req | output | 1 | Registered configuration-mismatch reset request |
| mm_first_idx | output | AW | Index that tripped the monitor first |

## Verification
The assertions assume three things about the inputs. `wr_addr` and `inj_idx` stay below NREG whenever their strobes are high. The live bank follows the same lock rule as the block and updates on the same edge. The inputs carry no unknown values after reset. The bench models the register file with exactly that acceptance rule, applies upsets through a separate flip vector on its clock edge, and draws every index from the range 0 to NREG-1. As a result, the only mismatches it produces are the deliberate ones.

// File: rtl/cfgmon_pkg.sv
package cfgmon_pkg;

    typedef enum logic [0:0] {
        MON_ARMED   = 1'b0,
        MON_TRIPPED = 1'b1
    } mon_state_e;

endpackage

// File: rtl/cfgmon_shadow_bank.sv
module cfgmon_shadow_bank #(
    parameter int NREG = 8,
    parameter int W    = 16,
    parameter int AW   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_req,
    input  logic              wr_locked,
    input  logic [AW-1:0]     wr_addr,
    input  logic [W-1:0]      wr_data,
    input  logic              inj_en,
    input  logic [AW-1:0]     inj_idx,
    input  logic [W-1:0]      inj_mask,
    output logic [NREG*W-1:0] shadow_flat
);

    logic accept;
    assign accept = wr_req && !wr_locked;

    for (genvar g = 0; g < NREG; g++) begin : g_copy
        logic [W-1:0] shd_q;
        logic [W-1:0] base;
        logic [W-1:0] shd_d;
        logic         wr_hit;
        logic         inj_hit;

        assign wr_hit  = accept && (wr_addr == AW'(g));
        assign inj_hit = inj_en && (inj_idx == AW'(g));

        always_comb begin
            base  = wr_hit  ? wr_data      : shd_q;
            shd_d = inj_hit ? base ^ inj_mask : base;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                shd_q <= '0;
            end else begin
                shd_q <= shd_d;
            end
        end

        assign shadow_flat[g*W +: W] = shd_q;

        // R2: an accepted write lands in this copy on the same edge
        p_accept_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_req && !wr_locked && wr_addr == AW'(g) && !inj_en)
            |=> (shadow_flat[g*W +: W] == $past(wr_data)));
    end

    // R3: without an accepted write or an injection, the copies do not move
    p_locked_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!(wr_req && !wr_locked) && !inj_en) |=> $stable(shadow_flat));

endmodule

// File: rtl/cfgmon_diff_scan.sv
module cfgmon_diff_scan #(
    parameter int NREG = 8,
    parameter int W    = 16,
    parameter int AW   = 3
) (
    input  logic [NREG*W-1:0] live_flat,
    input  logic [NREG*W-1:0] shadow_flat,
    output logic              mismatch_any,
    output logic [AW-1:0]     mismatch_idx
);

    logic [NREG-1:0] diff_vec;

    for (genvar g = 0; g < NREG; g++) begin : g_cmp
        assign diff_vec[g] = |(live_flat[g*W +: W] ^ shadow_flat[g*W +: W]);
    end

    assign mismatch_any = |diff_vec;

    // lowest differing index wins
    always_comb begin
        mismatch_idx = '0;
        for (int i = NREG - 1; i >= 0; i--) begin
            if (diff_vec[i]) begin
                mismatch_idx = AW'(i);
            end
        end
    end

endmodule

// File: rtl/cfgmon_trip_fsm.sv
module cfgmon_trip_fsm
    import cfgmon_pkg::*;
#(
    parameter int AW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mismatch_any,
    input  logic [AW-1:0] mismatch_idx,
    output logic          reset_req,
    output logic [AW-1:0] first_idx
);

    mon_state_e state_q;
    mon_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MON_ARMED:   if (mismatch_any) state_d = MON_TRIPPED;
            MON_TRIPPED: state_d = MON_TRIPPED;
            default:     state_d = MON_ARMED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= MON_ARMED;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            first_idx <= '0;
        end else if (state_q == MON_ARMED && state_d == MON_TRIPPED) begin
            first_idx <= mismatch_idx;
        end
    end

    assign reset_req = (state_q == MON_TRIPPED);

    // R4: any mismatch seen while armed produces the request on the next edge
    p_trip_next_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!reset_req && mismatch_any) |=> reset_req);

    // R6: the request never drops before reset
    p_hold_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |=> reset_req);

    // R7: the index captured on the trip is the scan result of that cycle
    p_idx_capture_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!reset_req && mismatch_any) |=> (first_idx == $past(mismatch_idx)));

    // R7: the captured index holds afterwards
    p_idx_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |=> $stable(first_idx));

    // R7: the index stays zero while nothing has tripped
    p_idx_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !reset_req |-> (first_idx == '0));

endmodule

// File: rtl/cfgmon_top.sv
module cfgmon_top #(
    parameter int  NREG = 8,
    parameter int  W    = 16,
    localparam int AW   = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NREG*W-1:0] live_regs,
    input  logic              wr_req,
    input  logic              wr_locked,
    input  logic [AW-1:0]     wr_addr,
    input  logic [W-1:0]      wr_data,
    input  logic              inj_en,
    input  logic [AW-1:0]     inj_idx,
    input  logic [W-1:0]      inj_mask,
    output logic              mm_reset_req,
    output logic [AW-1:0]     mm_first_idx
);

    logic [NREG*W-1:0] shadow_flat;
    logic              mismatch_any;
    logic [AW-1:0]     mismatch_idx;

    cfgmon_shadow_bank #(.NREG(NREG), .W(W), .AW(AW)) u_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_req      (wr_req),
        .wr_locked   (wr_locked),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .inj_en      (inj_en),
        .inj_idx     (inj_idx),
        .inj_mask    (inj_mask),
        .shadow_flat (shadow_flat)
    );

    cfgmon_diff_scan #(.NREG(NREG), .W(W), .AW(AW)) u_scan (
        .live_flat    (live_regs),
        .shadow_flat  (shadow_flat),
        .mismatch_any (mismatch_any),
        .mismatch_idx (mismatch_idx)
    );

    cfgmon_trip_fsm #(.AW(AW)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .mismatch_any (mismatch_any),
        .mismatch_idx (mismatch_idx),
        .reset_req    (mm_reset_req),
        .first_idx    (mm_first_idx)
    );

    // R1: a tripped request is only possible after the live bank and the copies disagreed
    p_no_spurious_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!mm_reset_req && live_regs == shadow_flat) |=> !mm_reset_req);

endmodule

// File: tb/cfgmon_top_bench.sv
`timescale 1ns/1ps
module cfgmon_top_bench;

    localparam int NREG = 8;
    localparam int W    = 16;
    localparam int AW   = 3;

    typedef struct packed {
        logic [1:0]    kind;   // 0 write, 1 locked write, 2 live flip, 3 copy inject
        logic [AW-1:0] idx;
        logic [W-1:0]  val;
        logic          exp_req;
        logic [AW-1:0] exp_idx;
    } vec_t;

    localparam int NVEC = 8;
    localparam vec_t TBL [NVEC] = '{
        '{kind: 2'd0, idx: 3'd0, val: 16'hA5A5, exp_req: 1'b0, exp_idx: 3'd0}, // R2
        '{kind: 2'd0, idx: 3'd7, val: 16'hFFFF, exp_req: 1'b0, exp_idx: 3'd0}, // R2
        '{kind: 2'd1, idx: 3'd3, val: 16'h1234, exp_req: 1'b0, exp_idx: 3'd0}, // R3
        '{kind: 2'd2, idx: 3'd4, val: 16'h0001, exp_req: 1'b1, exp_idx: 3'd4}, // R4
        '{kind: 2'd2, idx: 3'd0, val: 16'h8000, exp_req: 1'b1, exp_idx: 3'd0}, // R9
        '{kind: 2'd3, idx: 3'd6, val: 16'h0100, exp_req: 1'b1, exp_idx: 3'd6}, // R5
        '{kind: 2'd1, idx: 3'd1, val: 16'hFFFF, exp_req: 1'b0, exp_idx: 3'd0}, // R3
        '{kind: 2'd3, idx: 3'd2, val: 16'h0000, exp_req: 1'b0, exp_idx: 3'd0}  // R5
    };

    logic              clk = 1'b0;
    logic              rst_n;
    logic [NREG*W-1:0] live_q;
    logic [NREG*W-1:0] live_d;
    logic [NREG*W-1:0] tb_flip;
    logic              wr_req;
    logic              wr_locked;
    logic [AW-1:0]     wr_addr;
    logic [W-1:0]      wr_data;
    logic              inj_en;
    logic [AW-1:0]     inj_idx;
    logic [W-1:0]      inj_mask;
    logic              mm_reset_req;
    logic [AW-1:0]     mm_first_idx;

    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;

    // register-file model: same acceptance rule, upsets through tb_flip
    always_comb begin
        live_d = live_q;
        if (wr_req && !wr_locked) live_d[wr_addr*W +: W] = wr_data;
        live_d = live_d ^ tb_flip;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) live_q <= '0;
        else        live_q <= live_d;
    end

    cfgmon_top #(.NREG(NREG), .W(W)) u_cfgmon_top (
        .clk          (clk),
        .rst_n        (rst_n),
        .live_regs    (live_q),
        .wr_req       (wr_req),
        .wr_locked    (wr_locked),
        .wr_addr      (wr_addr),
        .wr_data      (wr_data),
        .inj_en       (inj_en),
        .inj_idx      (inj_idx),
        .inj_mask     (inj_mask),
        .mm_reset_req (mm_reset_req),
        .mm_first_idx (mm_first_idx)
    );

    task automatic finish_run();
        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic idle_inputs();
        wr_req = 1'b0; wr_locked = 1'b0; wr_addr = '0; wr_data = '0;
        inj_en = 1'b0; inj_idx = '0; inj_mask = '0; tb_flip = '0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        idle_inputs();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic flip_bits(input int idx, input logic [W-1:0] mask);
        @(negedge clk);
        tb_flip = '0;
        tb_flip[idx*W +: W] = mask;
        @(negedge clk);
        tb_flip = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        idle_inputs();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk("R1 req after reset", 32'(mm_reset_req), 32'd0);
        chk("R1 idx after reset", 32'(mm_first_idx), 32'd0);
        repeat (5) @(negedge clk);
        chk("R1 quiet with zero bank", 32'(mm_reset_req), 32'd0);

        // table walk
        for (int v = 0; v < NVEC; v++) begin
            do_reset();
            @(negedge clk);
            unique case (TBL[v].kind)
                2'd0: begin wr_req = 1'b1; wr_locked = 1'b0; wr_addr = TBL[v].idx; wr_data = TBL[v].val; end
                2'd1: begin wr_req = 1'b1; wr_locked = 1'b1; wr_addr = TBL[v].idx; wr_data = TBL[v].val; end
                2'd2: begin tb_flip[TBL[v].idx*W +: W] = TBL[v].val; end
                default: begin inj_en = 1'b1; inj_idx = TBL[v].idx; inj_mask = TBL[v].val; end
            endcase
            @(negedge clk);
            idle_inputs();
            repeat (2) @(negedge clk);
            chk($sformatf("vector %0d req", v), 32'(mm_reset_req), 32'(TBL[v].exp_req));
            chk($sformatf("vector %0d idx", v), 32'(mm_first_idx), 32'(TBL[v].exp_idx));
        end

        // R2: back-to-back accepted writes to every register, then monitoring still live
        do_reset();
        for (int r = 0; r < NREG; r++) begin
            @(negedge clk);
            wr_req = 1'b1; wr_locked = 1'b0; wr_addr = AW'(r); wr_data = W'(16'h1111 * (r + 1));
        end
        @(negedge clk);
        idle_inputs();
        repeat (3) @(negedge clk);
        chk("R2 burst writes raise nothing", 32'(mm_reset_req), 32'd0);
        flip_bits(5, 16'h0040);
        @(negedge clk);
        chk("R4 flip after burst trips", 32'(mm_reset_req), 32'd1);
        chk("R7 idx after burst flip", 32'(mm_first_idx), 32'd5);

        // R3: burst of locked writes
        do_reset();
        for (int r = 0; r < NREG; r++) begin
            @(negedge clk);
            wr_req = 1'b1; wr_locked = 1'b1; wr_addr = AW'(r); wr_data = 16'hDEAD;
        end
        @(negedge clk);
        idle_inputs();
        repeat (3) @(negedge clk);
        chk("R3 locked burst raises nothing", 32'(mm_reset_req), 32'd0);

        // R4: exact latency - not yet up one edge after the flip
        do_reset();
        @(negedge clk);
        tb_flip[3*W +: W] = 16'h0002;
        @(negedge clk);
        tb_flip = '0;
        chk("R4 not raised after first edge", 32'(mm_reset_req), 32'd0);
        @(negedge clk);
        chk("R4 raised after second edge", 32'(mm_reset_req), 32'd1);

        // R6: restore live value, request holds
        flip_bits(3, 16'h0002);
        repeat (4) @(negedge clk);
        chk("R6 held after live restored", 32'(mm_reset_req), 32'd1);
        chk("R7 idx held", 32'(mm_first_idx), 32'd3);

        // R7: simultaneous flips report the lowest index
        do_reset();
        @(negedge clk);
        tb_flip[6*W +: W] = 16'h0800;
        tb_flip[2*W +: W] = 16'h0010;
        @(negedge clk);
        tb_flip = '0;
        repeat (2) @(negedge clk);
        chk("R7 lowest of simultaneous", 32'(mm_first_idx), 32'd2);

        // R7: later lower-index mismatch does not overwrite
        do_reset();
        flip_bits(5, 16'h0004);
        @(negedge clk);
        flip_bits(1, 16'h0004);
        repeat (2) @(negedge clk);
        chk("R7 first index kept", 32'(mm_first_idx), 32'd5);

        // R9: MSB of the top register
        do_reset();
        flip_bits(NREG - 1, 16'h8000);
        @(negedge clk);
        chk("R9 top register MSB trips", 32'(mm_reset_req), 32'd1);
        chk("R9 top register index", 32'(mm_first_idx), 32'd7);

        // R8: reset clears a pending request, monitoring resumes
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        chk("R8 request cleared in reset", 32'(mm_reset_req), 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R8 stays clear after release", 32'(mm_reset_req), 32'd0);
        chk("R8 idx cleared", 32'(mm_first_idx), 32'd0);
        @(negedge clk);
        wr_req = 1'b1; wr_addr = 3'd4; wr_data = 16'h0F0F;
        @(negedge clk);
        idle_inputs();
        repeat (2) @(negedge clk);
        chk("R8 legal write after reset quiet", 32'(mm_reset_req), 32'd0);
        // R5: injection in a copy after an accepted write still trips
        @(negedge clk);
        inj_en = 1'b1; inj_idx = 3'd4; inj_mask = 16'h0001;
        @(negedge clk);
        idle_inputs();
        @(negedge clk);
        chk("R5 inject trips", 32'(mm_reset_req), 32'd1);
        chk("R5 inject index", 32'(mm_first_idx), 32'd4);

        finish_run();
    end

endmodule